// File: doc/BRIEF.md
# GPIO Edge-Event Interrupt Detector

This block watches 54 general-purpose pins and records edges. Software sets each pin's direction. Software can arm each pin to capture rising edges, falling edges or both. Pins set as outputs drive the value held in an output register and never record an event. Inputs pass through a two-stage synchronizer. An edge on an input is found by comparing the synchronized level with its value one cycle earlier. A detected edge of an armed polarity sets a sticky event bit. Software clears that bit by writing a one to it.

All per-pin state is held as 54-bit vectors and is accessed as pairs of 32-bit words. The low word holds pins 0–31. The high word holds pins 32–53 in bits 21:0. A register address is `{selector[2:0], half}`, where `half` = 0 selects the low word and `half` = 1 selects the high word. The selectors are:

| Selector | Register |
|----------|----------|
| 0 | direction (1 = output) |
| 1 | output value |
| 2 | rising-edge arm |
| 3 | falling-edge arm |
| 4 | event status (write 1 to clear) |
| 5 | synchronized input level (read only) |

Reads are combinational from the address. Pending events are merged into three level interrupt lines. Line 0 serves pins 0–27, line 1 serves pins 28–45 and line 2 serves pins 46–53. These lines feed three consecutive inputs of an external interrupt controller.

Top module: `gpio_evt_top`

## Requirements
- R1: After reset, every readable register returns 0, `pin_oe_o` and `pin_o` are 0, and `irq_o` is 0.
- R2: `pin_oe_o` follows the direction register, and `pin_o` follows the output value register, from the cycle after the write.
- R3: An input pin with its rising arm bit set gets its event bit set once its synchronized level goes 0→1. The bit is readable 3 clock edges after the pin changes.
- R4: An input pin with its falling arm bit set gets its event bit set once its synchronized level goes 1→0. With both arm bits set, edges of both polarities are recorded.
- R5: An edge whose polarity is not armed leaves the event bit clear.
- R6: A pin whose direction bit is 1 never sets its event bit, whatever edges appear on `pin_i`.
- R7: An event bit stays set until software clears it, including after the pin returns to its former level.
- R8: A write to the event status word (selector 4) clears exactly the bits written as 1. Bits written as 0 keep their value.
- R9: Each `irq_o[g]` is the OR of the event bits in its range: line 0 covers pins 0–27, line 1 covers pins 28–45 and line 2 covers pins 46–53. A line drops only when every bit in its range is clear.
- R10: Bits 31:22 of every high word read as 0, and writes to those bits have no effect.
- R11: If an edge is detected in the same cycle as a clear write to that pin's event bit, the bit ends up set.
- R12: Selector 5 returns the synchronized pin levels.
- R13: The direction, output and arm registers read back the value last written, in both halves.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | 54 | Pin levels from the pads (asynchronous) |
| pin_o | output | 54 | Driven output levels |
| pin_oe_o | output | 54 | Output enables (the direction bits) |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address {selector, half} |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i |
| irq_o | output | 3 | Grouped interrupt lines |

## Verification
The hardest case to reach from the ports is a clear write that lands in the same cycle as a new edge on the same pin. The write strobe must be placed exactly on the edge where the pin's change leaves the synchronizer. The bench does this by changing the pin on a falling clock edge and waiting two more falling edges. It then drives the clear, so that the write is sampled together with the edge detection, and reads the bit back afterwards. Group boundaries are exercised with pins 27/28 and 45/46. Overlapping pending bits within one group show that a line holds until its last bit is cleared.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;
  localparam int unsigned NPIN   = 54;
  localparam int unsigned WORD   = 32;
  localparam int unsigned NGRP   = 3;
  localparam int unsigned ADDR_W = 4;
  // first pin of each group, plus end marker
  localparam int unsigned GRP_EDGE [NGRP+1] = '{0, 28, 46, 54};

  typedef enum logic [2:0] {
    S_DIR  = 3'd0,
    S_OUT  = 3'd1,
    S_RISE = 3'd2,
    S_FALL = 3'd3,
    S_EVT  = 3'd4,
    S_LVL  = 3'd5
  } reg_sel_e;

  function automatic logic [NPIN-1:0] grp_mask(input int unsigned g);
    logic [NPIN-1:0] m;
    for (int unsigned p = 0; p < NPIN; p++)
      m[p] = (p >= GRP_EDGE[g]) && (p < GRP_EDGE[g+1]);
    return m;
  endfunction
endpackage

// File: rtl/gpio_evt_sync.sv
module gpio_evt_sync #(
  parameter int unsigned W      = 54,
  parameter int unsigned STAGES = 2   // must be >= 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else         st_q <= {st_q[STAGES-2:0], d_i};
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/gpio_evt_cfg.sv
module gpio_evt_cfg
  import gpio_evt_pkg::*;
#(
  parameter int unsigned NP = NPIN,
  parameter int unsigned DW = WORD
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic [NP-1:0]     evt_i,
  input  logic [NP-1:0]     lvl_i,
  output logic [NP-1:0]     dir_o,
  output logic [NP-1:0]     out_o,
  output logic [NP-1:0]     rise_o,
  output logic [NP-1:0]     fall_o,
  output logic [NP-1:0]     clr_o
);
  localparam int unsigned HW  = NP - DW;
  localparam int unsigned PAD = 2*DW - NP;

  logic     hi;
  reg_sel_e sel;
  logic [NP-1:0] dir_q, out_q, rise_q, fall_q;

  assign hi  = addr_i[0];
  assign sel = reg_sel_e'(addr_i[ADDR_W-1:1]);

  // merge one word into a full vector; unused high bits dropped
  function automatic logic [NP-1:0] put(input logic [NP-1:0] cur,
                                        input logic h,
                                        input logic [DW-1:0] d);
    if (h) return {d[HW-1:0], cur[DW-1:0]};
    else   return {cur[NP-1:DW], d};
  endfunction

  function automatic logic [DW-1:0] get(input logic [NP-1:0] v, input logic h);
    if (h) return {{PAD{1'b0}}, v[NP-1:DW]};
    else   return v[DW-1:0];
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= '0;
      out_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
    end else if (we_i) begin
      case (sel)
        S_DIR:   dir_q  <= put(dir_q,  hi, wdata_i);
        S_OUT:   out_q  <= put(out_q,  hi, wdata_i);
        S_RISE:  rise_q <= put(rise_q, hi, wdata_i);
        S_FALL:  fall_q <= put(fall_q, hi, wdata_i);
        default: ;
      endcase
    end
  end

  assign clr_o = (we_i && sel == S_EVT) ? put('0, hi, wdata_i) : '0;

  always_comb begin
    case (sel)
      S_DIR:   rdata_o = get(dir_q,  hi);
      S_OUT:   rdata_o = get(out_q,  hi);
      S_RISE:  rdata_o = get(rise_q, hi);
      S_FALL:  rdata_o = get(fall_q, hi);
      S_EVT:   rdata_o = get(evt_i,  hi);
      S_LVL:   rdata_o = get(lvl_i,  hi);
      default: rdata_o = '0;
    endcase
  end

  assign dir_o  = dir_q;
  assign out_o  = out_q;
  assign rise_o = rise_q;
  assign fall_o = fall_q;
endmodule

// File: rtl/gpio_evt_status.sv
module gpio_evt_status #(
  parameter int unsigned NP = 54
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NP-1:0] lvl_i,
  input  logic [NP-1:0] dir_i,
  input  logic [NP-1:0] rise_en_i,
  input  logic [NP-1:0] fall_en_i,
  input  logic [NP-1:0] clr_i,
  output logic [NP-1:0] evt_o
);
  logic [NP-1:0] prev_q, evt_q, hit;

  // only inputs record; a new hit beats a simultaneous clear
  assign hit = ((lvl_i & ~prev_q & rise_en_i) |
                (~lvl_i & prev_q & fall_en_i)) & ~dir_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      evt_q  <= '0;
    end else begin
      prev_q <= lvl_i;
      evt_q  <= (evt_q & ~clr_i) | hit;
    end
  end

  assign evt_o = evt_q;
endmodule

// File: rtl/gpio_evt_irq.sv
module gpio_evt_irq
  import gpio_evt_pkg::*;
#(
  parameter int unsigned NG = NGRP
) (
  input  logic [NPIN-1:0] evt_i,
  output logic [NG-1:0]   irq_o
);
  for (genvar g = 0; g < NG; g++) begin : g_line
    localparam logic [NPIN-1:0] MASK = grp_mask(g);
    assign irq_o[g] = |(evt_i & MASK);
  end
endmodule

// File: rtl/gpio_evt_top.sv
module gpio_evt_top
  import gpio_evt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NPIN-1:0]   pin_i,
  output logic [NPIN-1:0]   pin_o,
  output logic [NPIN-1:0]   pin_oe_o,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [WORD-1:0]   reg_wdata_i,
  output logic [WORD-1:0]   reg_rdata_o,
  output logic [NGRP-1:0]   irq_o
);
  logic [NPIN-1:0] lvl, dir, outv, rise_en, fall_en, clr, evt_q;

  gpio_evt_sync #(.W(NPIN), .STAGES(2)) u_sync (
    .clk_i, .rst_ni, .d_i(pin_i), .q_o(lvl)
  );

  gpio_evt_cfg #(.NP(NPIN), .DW(WORD)) u_cfg (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o), .evt_i(evt_q), .lvl_i(lvl),
    .dir_o(dir), .out_o(outv), .rise_o(rise_en), .fall_o(fall_en),
    .clr_o(clr)
  );

  gpio_evt_status #(.NP(NPIN)) u_stat (
    .clk_i, .rst_ni, .lvl_i(lvl), .dir_i(dir),
    .rise_en_i(rise_en), .fall_en_i(fall_en), .clr_i(clr), .evt_o(evt_q)
  );

  gpio_evt_irq #(.NG(NGRP)) u_irq (.evt_i(evt_q), .irq_o(irq_o));

  assign pin_o    = outv;
  assign pin_oe_o = dir;
endmodule

// File: rtl/gpio_evt_chk.sv
module gpio_evt_chk
  import gpio_evt_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [WORD-1:0]   reg_wdata_i,
  input logic [WORD-1:0]   reg_rdata_o,
  input logic [NPIN-1:0]   pin_oe_o,
  input logic [NGRP-1:0]   irq_o,
  input logic [NPIN-1:0]   evt_q
);
  logic [NPIN-1:0] clr_m;
  logic            hi_rd;

  always_comb begin
    clr_m = '0;
    if (reg_we_i && reg_addr_i == 4'd8) clr_m[WORD-1:0] = reg_wdata_i;
    if (reg_we_i && reg_addr_i == 4'd9) clr_m[NPIN-1:WORD] = reg_wdata_i[NPIN-WORD-1:0];
  end
  assign hi_rd = reg_addr_i[0] && (reg_addr_i < 4'd12);

  p_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |-> ((($past(evt_q) & ~$past(clr_m)) & ~evt_q) == '0));

  p_out_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |-> ((evt_q & ~$past(evt_q) & $past(pin_oe_o)) == '0));

  p_hi_pad_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_rd |-> (reg_rdata_o[WORD-1:NPIN-WORD] == '0));

  p_irq_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_q == '0) |-> (irq_o == '0));

  p_irq_top_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_q[NPIN-1:46]) |-> irq_o[2]);

  p_oe_follow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == 4'd0) |=> (pin_oe_o[WORD-1:0] == $past(reg_wdata_i)));
endmodule

bind gpio_evt_top gpio_evt_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
  .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .pin_oe_o(pin_oe_o),
  .irq_o(irq_o), .evt_q(evt_q)
);

// File: tb/tb_gpio_evt_top.sv
`timescale 1ns/100ps
module tb_gpio_evt_top;
  localparam logic [3:0] DIR_L=0, DIR_H=1, OUT_L=2, OUT_H=3, RISE_L=4, RISE_H=5,
                         FALL_L=6, FALL_H=7, EVT_L=8, EVT_H=9, LVL_L=10, LVL_H=11;

  logic        clk = 0, rst_ni = 0;
  logic [53:0] pin_i = '0, pin_o, pin_oe_o;
  logic        reg_we_i = 0;
  logic [3:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0, reg_rdata_o;
  logic [2:0]  irq_o;
  int n_cmp = 0, n_bad = 0;

  always #2 clk = ~clk;

  gpio_evt_top dut (.clk_i(clk), .rst_ni, .pin_i, .pin_o, .pin_oe_o, .reg_we_i,
                    .reg_addr_i, .reg_wdata_i, .reg_rdata_o, .irq_o);

  task automatic chk(input string req, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_we_i = 1; reg_addr_i = a; reg_wdata_i = d;
    @(posedge clk); #1 reg_we_i = 0;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
    @(negedge clk); reg_addr_i = a; #0.5;
    chk(req, $sformatf("reg %0d", a), 64'(reg_rdata_o), 64'(exp));
  endtask

  task automatic settle; repeat (4) @(posedge clk); @(negedge clk); endtask

  task automatic set_pin(input int p, input logic v);
    @(negedge clk); pin_i[p] = v; settle();
  endtask

  task automatic t_reset;
    for (int a = 0; a < 12; a++) rd_chk("R1", 4'(a), 32'h0);
    chk("R1", "pin_oe", 64'(pin_oe_o), 0);
    chk("R1", "pin_o", 64'(pin_o), 0);
    chk("R1", "irq", 64'(irq_o), 0);
  endtask

  task automatic t_regs;
    wr(DIR_L, 32'hA5A5_0F0F); wr(DIR_H, 32'hFFFF_FFFF);
    wr(OUT_L, 32'h1234_5678); wr(OUT_H, 32'h0012_3456);
    wr(RISE_L, 32'hDEAD_BEEF); wr(FALL_H, 32'hFFC0_0001);
    rd_chk("R13", DIR_L, 32'hA5A5_0F0F);
    rd_chk("R10", DIR_H, 32'h003F_FFFF);
    rd_chk("R13", OUT_H, 32'h0012_3456);
    rd_chk("R13", RISE_L, 32'hDEAD_BEEF);
    rd_chk("R10", FALL_H, 32'h0000_0001);
    @(negedge clk);
    chk("R2", "pin_oe", 64'(pin_oe_o), {10'h0, 22'h3F_FFFF, 32'hA5A5_0F0F});
    chk("R2", "pin_o", 64'(pin_o), {10'h0, 22'h12_3456, 32'h1234_5678});
    for (int a = 0; a < 8; a++) wr(4'(a), 32'h0);
  endtask

  task automatic t_rise;
    wr(RISE_L, 32'h20);
    set_pin(5, 1);
    rd_chk("R3", EVT_L, 32'h20);
    chk("R9", "irq after pin5", 64'(irq_o), 3'b001);
    set_pin(5, 0);
    rd_chk("R7", EVT_L, 32'h20);
    wr(EVT_L, 32'h40); @(negedge clk);
    rd_chk("R8", EVT_L, 32'h20);
    wr(EVT_L, 32'h20); @(negedge clk);
    rd_chk("R8", EVT_L, 32'h0);
    chk("R9", "irq cleared", 64'(irq_o), 0);
    wr(RISE_L, 0);
  endtask

  task automatic t_fall;
    wr(FALL_H, 32'h100);            // pin 40
    set_pin(40, 1);
    rd_chk("R5", EVT_H, 32'h0);
    set_pin(40, 0);
    rd_chk("R4", EVT_H, 32'h100);
    chk("R9", "irq pin40", 64'(irq_o), 3'b010);
    wr(EVT_H, 32'h100); wr(FALL_H, 0);
    wr(RISE_H, 32'h4_0000); wr(FALL_H, 32'h4_0000);   // pin 50 both
    set_pin(50, 1);
    rd_chk("R4", EVT_H, 32'h4_0000);
    chk("R9", "irq pin50", 64'(irq_o), 3'b100);
    wr(EVT_H, 32'h4_0000);
    set_pin(50, 0);
    rd_chk("R4", EVT_H, 32'h4_0000);
    wr(EVT_H, 32'h4_0000); wr(RISE_H, 0); wr(FALL_H, 0);
  endtask

  task automatic t_groups;
    wr(RISE_L, 32'h1800_0000);                 // pins 27,28
    wr(RISE_H, 32'h0020_6000);                 // pins 45,46,53
    set_pin(27, 1);
    chk("R9", "pin27 line0", 64'(irq_o), 3'b001);
    wr(EVT_L, 32'h0800_0000);
    set_pin(28, 1);
    chk("R9", "pin28 line1", 64'(irq_o), 3'b010);
    set_pin(45, 1);
    wr(EVT_L, 32'h1000_0000); @(negedge clk);
    chk("R9", "line1 held by pin45", 64'(irq_o), 3'b010);
    wr(EVT_H, 32'h2000); @(negedge clk);
    chk("R9", "line1 dropped", 64'(irq_o), 3'b000);
    set_pin(46, 1); set_pin(53, 1);
    chk("R9", "pins46,53 line2", 64'(irq_o), 3'b100);
    wr(EVT_H, 32'h4000); @(negedge clk);
    chk("R9", "line2 held by pin53", 64'(irq_o), 3'b100);
    wr(EVT_H, 32'h20_0000); @(negedge clk);
    chk("R9", "line2 dropped", 64'(irq_o), 3'b000);
    wr(RISE_L, 0); wr(RISE_H, 0);
  endtask

  task automatic t_output;
    wr(DIR_L, 32'h400); wr(OUT_L, 32'h400); wr(RISE_L, 32'h400); wr(FALL_L, 32'h400);
    set_pin(10, 1); set_pin(10, 0);
    rd_chk("R6", EVT_L, 32'h0);
    chk("R6", "irq", 64'(irq_o), 0);
    chk("R2", "pin_o[10]", 64'(pin_o[10]), 1);
    wr(DIR_L, 0); wr(OUT_L, 0); wr(RISE_L, 0); wr(FALL_L, 0);
  endtask

  task automatic t_race;
    wr(RISE_L, 32'h8); wr(FALL_L, 32'h8);
    set_pin(3, 1);
    rd_chk("R11", EVT_L, 32'h8);
    @(negedge clk); pin_i[3] = 0;
    @(negedge clk);
    @(negedge clk); reg_we_i = 1; reg_addr_i = EVT_L; reg_wdata_i = 32'h8;
    @(posedge clk); #1 reg_we_i = 0;
    rd_chk("R11", EVT_L, 32'h8);
    wr(EVT_L, 32'h8);
    rd_chk("R8", EVT_L, 32'h0);
    wr(RISE_L, 0); wr(FALL_L, 0);
  endtask

  task automatic t_level;
    @(negedge clk); pin_i = {22'h2A_5A5A, 32'hC3C3_1234};
    settle();
    rd_chk("R12", LVL_L, 32'hC3C3_1234);
    rd_chk("R12", LVL_H, 32'h002A_5A5A);
    rd_chk("R5", EVT_L, 32'h0);
  endtask

  initial begin
    #400000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1;
    t_reset();
    t_regs();
    t_rise();
    t_fall();
    t_groups();
    t_output();
    t_race();
    t_level();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule